// File: doc/BRIEF.md
# Cascadable FIFO Stage with Token-Passing Depth Expansion

This block is one stage of a deep first-in first-out buffer built from several identical stages joined in a ring. A write token and a read token travel around the ring. The stage that holds the write token stores the words offered on the shared write port. The stage that holds the read token supplies the words taken from the shared read port. Every stage sees the same write enable, write data and read enable. Only the owner of a port acts on it, so the ring behaves as one buffer whose depth is the sum of the stage depths.

A stage gives up a token when it uses its last physical location, and at the same moment it raises a one-cycle token-out strobe. The next stage in the ring samples that strobe on the same clock edge and becomes the owner. Exactly one stage selects itself at reset through its first-load input and holds both tokens. The write side runs on the write clock and the read side runs on the read clock. Each stage keeps its own small storage array and a local write and read pointer. Combining the full and empty flags across stages is left to logic outside the block.

Top module: `cascade_fifo_stage`

## Requirements
- R1: While reset is held, and after it is released, a stage with first_load=1 owns both ports (wr_own=1, rd_own=1). A stage with first_load=0 owns neither. Both token-out strobes and rd_drive are 0.
- R2: wtok_out is 1 in exactly those write-clock cycles in which the stage owns the write port, wr_en=1, and its write pointer is at location DEPTH-1. The strobe never lasts two cycles in a row.
- R3: rtok_out is 1 in exactly those read-clock cycles in which the stage owns the read port, rd_en=1, and its read pointer is at location DEPTH-1. The strobe never lasts two cycles in a row.
- R4: A stage becomes owner of a port only on the edge that ends a cycle with the matching token-in at 1. It stops being owner only on the edge that ends a cycle with its own token-out at 1. In a ring, exactly one stage owns each port at all times.
- R5: A stage that does not own a port ignores that port's enable. Its pointer, storage and token-out for that port are unchanged.
- R6: One read-clock cycle after the owning stage accepts a read, rd_drive is 1 for one cycle and rd_data holds the stored word. rd_drive is 0 on every stage that did not accept a read on the previous edge.
- R7: Words written through the shared write port come out of the shared read port in write order. This holds across every stage boundary and across more than one lap of the ring, including simultaneous reads and writes.
- R8: Reset applied mid-stream discards all contents. Both tokens return to the first-load stage, and both of its pointers return to location 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| first_load | input | 1 | Marks the stage that holds both tokens after reset |
| wr_en | input | 1 | Shared write enable |
| wr_data | input | WIDTH | Shared write data |
| wtok_in | input | 1 | Write token strobe from the previous stage |
| wtok_out | output | 1 | Write token strobe to the next stage |
| wr_own | output | 1 | This stage owns the write port |
| rd_en | input | 1 | Shared read enable |
| rd_data | output | WIDTH | Registered read word |
| rd_drive | output | 1 | rd_data holds a word this stage just read |
| rtok_in | input | 1 | Read token strobe from the previous stage |
| rtok_out | output | 1 | Read token strobe to the next stage |
| rd_own | output | 1 | This stage owns the read port |

## Verification
The assertions rely on three properties of the inputs. A token-in strobe reaches a stage only when the previous stage in a correctly closed ring releases that token. First-load is set on one stage only. The shared enables never write into a full buffer or read from an empty one. The bench wires three four-entry stages into a ring and sets first-load on stage 0 alone. It keeps a reference occupancy count and masks each write enable when the buffer is full and each read enable when it is empty. Because of this masking, vectors that would overflow or underflow the buffer only exercise the blocked-request path.

// File: rtl/cascade_fifo_stage.sv
module cascade_fifo_stage #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             first_load,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wtok_in,
  output logic             wtok_out,
  output logic             wr_own,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive,
  input  logic             rtok_in,
  output logic             rtok_out,
  output logic             rd_own
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  wire wr_go = wr_en & wr_own;
  wire rd_go = rd_en & rd_own;

  assign wtok_out = wr_go & (wptr == LAST);
  assign rtok_out = rd_go & (rptr == LAST);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wr_own <= first_load;
      wptr   <= '0;
    end else begin
      wr_own <= (wr_own & ~wtok_out) | wtok_in;
      if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wptr] <= wr_data;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rd_own   <= first_load;
      rptr     <= '0;
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_own   <= (rd_own & ~rtok_out) | rtok_in;
      rd_drive <= rd_go;
      if (rd_go) begin
        rd_data <= mem[rptr];
        rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
      end
    end

  a_r2_wtok_from_owner: assert property (@(posedge wclk) disable iff (!rst_n)
    wtok_out |-> (wr_own && wr_en));
  a_r2_wtok_one_cycle: assert property (@(posedge wclk) disable iff (!rst_n)
    wtok_out |=> !wtok_out);
  a_r3_rtok_from_owner: assert property (@(posedge rclk) disable iff (!rst_n)
    rtok_out |-> (rd_own && rd_en));
  a_r3_rtok_one_cycle: assert property (@(posedge rclk) disable iff (!rst_n)
    rtok_out |=> !rtok_out);
  a_r4_wown_gain: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(wr_own) |-> $past(wtok_in));
  a_r4_wown_drop: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(wr_own) |-> $past(wtok_out));
  a_r4_rown_gain: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(rd_own) |-> $past(rtok_in));
  a_r4_rown_drop: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(rd_own) |-> $past(rtok_out));
  a_r6_drive_after_read: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_drive |-> $past(rd_own && rd_en));
endmodule

// File: tb/cascade_fifo_stage_bench.sv
module cascade_fifo_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int D = 4;
  localparam int N = 3;
  localparam int NV = 40;
  // bit1 = write request, bit0 = read request
  localparam logic [1:0] VEC [NV] = '{
    2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,2'b10,
    2'b10,2'b10,2'b10,2'b10,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,
    2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,
    2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, wr_en, rd_en;
  logic [W-1:0] wr_data, bus;
  logic [N-1:0] wti, wto, rti, rto, wown, rown, drv;
  logic [W-1:0] rdat [N];

  for (genvar g = 0; g < N; g++) begin : stage
    assign wti[g] = wto[(g + N - 1) % N];
    assign rti[g] = rto[(g + N - 1) % N];
    cascade_fifo_stage #(.WIDTH(W), .DEPTH(D)) u_cascade_fifo_stage (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .first_load(g == 0),
      .wr_en(wr_en), .wr_data(wr_data), .wtok_in(wti[g]), .wtok_out(wto[g]),
      .wr_own(wown[g]), .rd_en(rd_en), .rd_data(rdat[g]), .rd_drive(drv[g]),
      .rtok_in(rti[g]), .rtok_out(rto[g]), .rd_own(rown[g]));
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) if (drv[i]) bus |= rdat[i];
  end

  int vectors = 0, miscompares = 0;
  int wo, ro, wp, rp, wcnt;
  logic [W-1:0] q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    wo = 0; ro = 0; wp = 0; rp = 0; q.delete();
  endtask

  task automatic step(input bit w, input bit r);
    bit we, re;
    logic [N-1:0] ew, er;
    @(negedge clk);
    we = w && (q.size() < N*D);
    re = r && (q.size() > 0);
    wr_en = we; rd_en = re; wr_data = W'(wcnt * 7 + 3);
    #1;
    chk(wown == N'(1 << wo), "R4 write owner one-hot", 32'(wown), 32'(1 << wo));
    chk(rown == N'(1 << ro), "R4 read owner one-hot", 32'(rown), 32'(1 << ro));
    ew = (we && wp == D-1) ? N'(1 << wo) : '0;
    er = (re && rp == D-1) ? N'(1 << ro) : '0;
    chk(wto == ew, "R2 write token strobe", 32'(wto), 32'(ew));
    chk(rto == er, "R3 read token strobe", 32'(rto), 32'(er));
    chk((wto & ~N'(1 << wo)) == '0, "R5 non-owner write token quiet", 32'(wto), 32'(ew));
    @(posedge clk); #1;
    chk(drv == (re ? N'(1 << ro) : '0), "R6 read drive", 32'(drv), re ? 32'(1 << ro) : 0);
    if (re) begin
      chk(bus == q[0], "R7 read order", 32'(bus), 32'(q[0]));
      void'(q.pop_front());
      if (rp == D-1) begin rp = 0; ro = (ro + 1) % N; end else rp++;
    end
    if (we) begin
      q.push_back(wr_data);
      wcnt++;
      if (wp == D-1) begin wp = 0; wo = (wo + 1) % N; end else wp++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wcnt = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(wown == 3'b001, "R1 write owner at reset", 32'(wown), 1);
    chk(rown == 3'b001, "R1 read owner at reset", 32'(rown), 1);
    chk(wto == 0 && rto == 0 && drv == 0, "R1 strobes idle", 32'({wto, rto, drv}), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(wown == 3'b001 && rown == 3'b001, "R1 owners after release", 32'({wown, rown}), 32'h9);

    for (int i = 0; i < NV; i++) step(VEC[i][1], VEC[i][0]);
    chk(q.size() == 0, "R7 buffer drained", q.size(), 0);

    // R8 mid-stream reset
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    #1;
    chk(wown == 3'b001 && rown == 3'b001, "R8 owners after mid reset", 32'({wown, rown}), 32'h9);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    chk(q.size() == 0, "R8 restart drained", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule